// File: doc/BRIEF.md
# Serial Successive-Approximation Conversion Sequencer

This block is the digital control of an 8-bit successive-approximation converter that is read over a three-wire serial link. A host lowers an active-low select and toggles a serial clock. The block tracks the input for half a clock period. It then resolves one bit per falling clock edge. It drives the trial code to an external DAC and reads back a one-bit comparator verdict from the analog side.

Each bit leaves on the serial data line as soon as it is decided, starting with the MSB. Once the LSB is known, the same word is played out again from the LSB upwards; the LSB is not repeated. A build-time option drops that second pass and holds the last decided bit on the line instead. A conversion status flag marks the decision loop.

When select is high, the serial data and status outputs are released (their enables drop) and the sequence is frozen. If select and clock are held high together for a set number of system clock cycles, the sequencer returns to idle.

The serial clock and select are sampled by the system clock `clk_i`, which must run several times faster than the serial clock.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After `rst_ni` is released, `trial_o` is 0, `busy_o` is 0 and `dout_o` is 0.
- R2: `dout_en_o` and `busy_en_o` are 1 exactly while `cs_ni` is 0, which stands for high impedance whenever select is high.
- R3: After select falls from idle or done, the first rising serial clock edge starts tracking and loads `trial_o` with only bit N_BITS-1 set (8'h80 by default). No decision is made and `busy_o` stays 0 until the next falling edge.
- R4: On each falling serial clock edge of the decision loop, the current trial bit is kept when `cmp_i` is 1 and cleared when it is 0, and the next lower bit is set. With `cmp_i` = (target >= `trial_o`), `trial_o` equals the target after the eighth falling edge.
- R5: `dout_o` after the k-th falling edge (k = 1..8) is the decision just made for bit 8-k, MSB first. An edge counts at the first `clk_i` rising edge that samples `sclk_i` low after high, and the outputs update on that same edge.
- R6: With `LSB_READOUT`=1, falling edges 9 to 15 put result bits 1 up to 7 on `dout_o`, and every later falling edge drives 0.
- R7: With `LSB_READOUT`=0, after the eighth falling edge `dout_o` keeps result bit 0 on all further falling edges until select rises.
- R8: `busy_o` rises at the first decision and falls at the eighth decision.
- R9: While `cs_ni` is 1, serial clock edges are ignored and `trial_o`, `busy_o` and `dout_o` hold. A new select fall during a conversion resumes it rather than restarting it.
- R10: When `sclk_i` and `cs_ni` are both 1 at SEL_CYC consecutive `clk_i` rising edges (default 4), the sequencer goes idle with `trial_o` = 0 and `busy_o` = 0. Holding them for fewer edges changes nothing.
- R11: A select fall after a finished access (done state) starts a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial inputs |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low select |
| sclk_i | input | 1 | Serial clock |
| cmp_i | input | 1 | Comparator verdict, 1 when the input is at or above the DAC level |
| trial_o | output | N_BITS | Trial code to the DAC |
| dout_o | output | 1 | Serial data value |
| dout_en_o | output | 1 | Drive enable for `dout_o` |
| busy_o | output | 1 | Conversion status value |
| busy_en_o | output | 1 | Drive enable for `busy_o` |

## Verification
The bench drives the comparator from a behavioural model of target >= trial code. It runs targets of all zeros, all ones, alternating patterns, a lone MSB, a lone LSB and the value just below midscale. This separates a stuck or swapped keep/clear decision, a bit-order error in either serial pass and an off-by-one in the shared-LSB handoff. Two instances run together, one of each readout variant, so that the zero tail and the held final bit are told apart. A pause in the middle of a conversion, a select-and-clock-high window one cycle short of the limit, and a window that meets the limit show the difference between freeze, no-op and return to idle.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_TRACK, ST_CONV, ST_LSB, ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    SRC_HOLD, SRC_CMP, SRC_WORD, SRC_TAIL
  } dout_src_e;
endpackage

// File: rtl/sar_seq_edges.sv
module sar_seq_edges #(
  parameter int unsigned SEL_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_fall_o,
  output logic sel_rst_o
);
  localparam int unsigned CW = $clog2(SEL_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(SEL_CYC - 1);

  logic sclk_q, cs_q, both_hi;
  logic [CW-1:0] hi_cnt;

  assign both_hi = sclk_i & cs_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      hi_cnt <= '0;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
      if (!both_hi)         hi_cnt <= '0;
      else if (hi_cnt != LIM) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assign sclk_rise_o = ~sclk_q & sclk_i;
  assign sclk_fall_o = sclk_q & ~sclk_i;
  assign cs_fall_o   = cs_q & ~cs_ni;
  // fires on the SEL_CYC-th consecutive edge with both high
  assign sel_rst_o   = both_hi & (hi_cnt == LIM);
endmodule

// File: rtl/sar_seq_trial.sv
module sar_seq_trial #(
  parameter int unsigned N_BITS = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      load_i,
  input  logic                      decide_i,
  input  logic [$clog2(N_BITS)-1:0] idx_i,
  input  logic                      cmp_i,
  output logic [N_BITS-1:0]         code_o
);
  for (genvar j = 0; j < N_BITS; j++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      bit_q <= 1'b0;
      else if (clr_i)   bit_q <= 1'b0;
      else if (load_i)  bit_q <= (j == N_BITS - 1);
      else if (decide_i) begin
        if (int'(idx_i) == j)          bit_q <= cmp_i;
        else if (int'(idx_i) == j + 1) bit_q <= 1'b1;
      end
    end
    assign code_o[j] = bit_q;
  end
endmodule

// File: rtl/sar_seq_dout.sv
module sar_seq_dout
  import sar_seq_pkg::*;
#(
  parameter int unsigned N_BITS      = 8,
  parameter int unsigned LSB_READOUT = 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  dout_src_e                 src_i,
  input  logic                      cmp_i,
  input  logic [N_BITS-1:0]         word_i,
  input  logic [$clog2(N_BITS)-1:0] ptr_i,
  output logic                      dout_o
);
  logic dout_q, tail_d, nxt;

  if (LSB_READOUT != 0) begin : g_lsb
    assign tail_d = 1'b0;
  end else begin : g_hold
    assign tail_d = dout_q;
  end

  always_comb begin
    unique case (src_i)
      SRC_CMP:  nxt = cmp_i;
      SRC_WORD: nxt = word_i[ptr_i];
      SRC_TAIL: nxt = tail_d;
      default:  nxt = dout_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dout_q <= 1'b0;
    else if (clr_i) dout_q <= 1'b0;
    else            dout_q <= nxt;
  end

  assign dout_o = dout_q;
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int unsigned N_BITS      = 8,
  parameter int unsigned SEL_CYC     = 4,
  parameter int unsigned LSB_READOUT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              cmp_i,
  output logic [N_BITS-1:0] trial_o,
  output logic              dout_o,
  output logic              dout_en_o,
  output logic              busy_o,
  output logic              busy_en_o
);
  localparam int unsigned CNT_W = $clog2(N_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_BITS - 1);

  seq_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, idx;
  logic busy_q, busy_d;
  logic sclk_rise, sclk_fall, cs_fall, sel_rst;
  logic active, rise_ok, fall_ok;
  logic clr, load, decide, dclr;
  dout_src_e src;

  sar_seq_edges #(.SEL_CYC(SEL_CYC)) u_edges (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sclk_i),
    .cs_ni       (cs_ni),
    .sclk_rise_o (sclk_rise),
    .sclk_fall_o (sclk_fall),
    .cs_fall_o   (cs_fall),
    .sel_rst_o   (sel_rst)
  );

  assign active  = ~cs_ni;
  assign rise_ok = sclk_rise & active;
  assign fall_ok = sclk_fall & active;
  assign idx     = LAST - cnt_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    clr     = 1'b0;
    load    = 1'b0;
    decide  = 1'b0;
    dclr    = 1'b0;
    src     = SRC_HOLD;
    if (sel_rst) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      busy_d  = 1'b0;
      clr     = 1'b1;
      dclr    = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (cs_fall) begin
            state_d = ST_ARM;
            cnt_d   = '0;
            dclr    = 1'b1;
          end else if (fall_ok && state_q == ST_DONE) begin
            src = SRC_TAIL;
          end
        end
        ST_ARM: begin
          if (rise_ok) begin
            state_d = ST_TRACK;
            load    = 1'b1;
          end
        end
        ST_TRACK, ST_CONV: begin
          if (fall_ok) begin
            decide = 1'b1;
            src    = SRC_CMP;
            if (cnt_q == LAST) begin
              busy_d  = 1'b0;
              cnt_d   = CNT_W'(1);
              state_d = (LSB_READOUT != 0) ? ST_LSB : ST_DONE;
            end else begin
              busy_d  = 1'b1;
              cnt_d   = cnt_q + 1'b1;
              state_d = ST_CONV;
            end
          end
        end
        ST_LSB: begin
          if (fall_ok) begin
            src = SRC_WORD;
            if (cnt_q == LAST) begin
              state_d = ST_DONE;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
    end
  end

  sar_seq_trial #(.N_BITS(N_BITS)) u_trial (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .load_i   (load),
    .decide_i (decide),
    .idx_i    (idx),
    .cmp_i    (cmp_i),
    .code_o   (trial_o)
  );

  sar_seq_dout #(.N_BITS(N_BITS), .LSB_READOUT(LSB_READOUT)) u_dout (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (dclr),
    .src_i  (src),
    .cmp_i  (cmp_i),
    .word_i (trial_o),
    .ptr_i  (cnt_q),
    .dout_o (dout_o)
  );

  assign busy_o    = busy_q;
  assign dout_en_o = active;
  assign busy_en_o = active;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk
  import sar_seq_pkg::*;
#(
  parameter int unsigned N_BITS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              sclk_rise_i,
  input logic              sclk_fall_i,
  input logic              sel_rst_i,
  input seq_state_e        state_i,
  input logic [N_BITS-1:0] trial_i,
  input logic              dout_i,
  input logic              busy_i
);
  localparam logic [N_BITS-1:0] MSB_ONLY = {1'b1, {(N_BITS-1){1'b0}}};

  AST_HOLD_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && !sel_rst_i) |=> ($stable(trial_i) && $stable(busy_i) && $stable(dout_i))); // R9

  AST_SEL_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_rst_i |=> (trial_i == '0 && !busy_i && state_i == ST_IDLE)); // R10

  AST_TRACK_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_TRACK) |-> (trial_i == MSB_ONLY && !busy_i)); // R3

  AST_TRIAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sclk_fall_i && !sclk_rise_i && !sel_rst_i) |=> $stable(trial_i)); // R4

  AST_BUSY_IN_LOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (state_i == ST_CONV)); // R8

  AST_BUSY_ROSE_FROM_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> ($past(state_i) == ST_TRACK)); // R8

  AST_ARM_DOUT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ARM) |-> !dout_i); // R3
endmodule

bind sar_seq_ctrl sar_seq_chk #(.N_BITS(N_BITS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .sclk_rise_i (sclk_rise),
  .sclk_fall_i (sclk_fall),
  .sel_rst_i   (sel_rst),
  .state_i     (state_q),
  .trial_i     (trial_o),
  .dout_i      (dout_o),
  .busy_i      (busy_o)
);

// File: tb/tb_sar_seq_ctrl.sv
`timescale 1ns/1ps
module tb_sar_seq_ctrl;
  localparam int N    = 8;
  localparam int SEL  = 4;
  localparam int HALF = 3;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0;
  logic [N-1:0] tgt = '0;
  logic [N-1:0] trial_a, trial_b;
  logic dout_a, dout_b, den_a, den_b, busy_a, busy_b, ben_a, ben_b;
  logic cmp_a, cmp_b;

  int checks = 0, errors = 0;
  bit q_a[$];
  bit q_b[$];

  always #2.5 clk = ~clk;

  assign cmp_a = (tgt >= trial_a);
  assign cmp_b = (tgt >= trial_b);

  sar_seq_ctrl #(.N_BITS(N), .SEL_CYC(SEL), .LSB_READOUT(1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .cmp_i(cmp_a),
    .trial_o(trial_a), .dout_o(dout_a), .dout_en_o(den_a),
    .busy_o(busy_a), .busy_en_o(ben_a)
  );

  sar_seq_ctrl #(.N_BITS(N), .SEL_CYC(SEL), .LSB_READOUT(0)) dut_hold (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .cmp_i(cmp_b),
    .trial_o(trial_b), .dout_o(dout_b), .dout_en_o(den_b),
    .busy_o(busy_b), .busy_en_o(ben_b)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // R2: enables follow select on every clock
  always @(posedge clk) begin
    if (rst_n) begin
      check_eq("R2", "enables", {den_a, ben_a, den_b, ben_b}, {4{~cs_n}});
    end
  end

  task automatic rise_edge();
    @(negedge clk) sclk = 1'b1;
    tick(HALF);
  endtask

  task automatic pause_mid();
    logic [N-1:0] ta, tb;
    logic ba, da;
    ta = trial_a; tb = trial_b; ba = busy_a; da = dout_a;
    cs_n = 1'b1;
    tick(2);
    sclk = 1'b1;
    tick(2);
    sclk = 1'b0;
    tick(2);
    check_eq("R9", "trial_a frozen", trial_a, ta);
    check_eq("R9", "trial_b frozen", trial_b, tb);
    check_eq("R9", "busy frozen", busy_a, ba);
    check_eq("R9", "dout frozen", dout_a, da);
    cs_n = 1'b0;
    tick(2);
  endtask

  task automatic run_access(logic [N-1:0] t, int n_falls, int pause_at, string start_req);
    tgt = t;
    q_a.delete();
    q_b.delete();
    for (int i = N - 1; i >= 0; i--) begin
      q_a.push_back(t[i]);
      q_b.push_back(t[i]);
    end
    for (int i = 1; i < N; i++) q_a.push_back(t[i]);
    while (q_a.size() < n_falls) q_a.push_back(1'b0);
    while (q_b.size() < n_falls) q_b.push_back(t[0]);

    @(negedge clk) cs_n = 1'b0;
    tick(2);
    rise_edge();
    check_eq(start_req, "track code", trial_a, 1 << (N - 1));
    check_eq(start_req, "busy in track", busy_a, 0);
    for (int k = 1; k <= n_falls; k++) begin
      bit ea, eb;
      @(negedge clk) sclk = 1'b0;
      @(negedge clk);
      ea = q_a.pop_front();
      eb = q_b.pop_front();
      if (k <= N) begin
        check_eq("R5", "msb-first bit", dout_a, ea);
        check_eq("R5", "msb-first bit hold variant", dout_b, eb);
      end else begin
        check_eq("R6", "lsb-first bit", dout_a, ea);
        check_eq("R7", "held final bit", dout_b, eb);
      end
      check_eq("R8", "busy", busy_a, (k < N) ? 1 : 0);
      check_eq("R8", "busy hold variant", busy_b, (k < N) ? 1 : 0);
      if (k == N) begin
        check_eq("R4", "result", trial_a, t);
        check_eq("R4", "result hold variant", trial_b, t);
      end
      tick(HALF - 1);
      if (k == pause_at) pause_mid();
      rise_edge();
    end
    @(negedge clk) sclk = 1'b0;
    tick(1);
    cs_n = 1'b1;
    tick(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] saved;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    check_eq("R1", "trial after reset", trial_a, 0);
    check_eq("R1", "busy after reset", busy_a, 0);
    check_eq("R1", "dout after reset", dout_a, 0);

    run_access(8'hA5, 18, 0, "R3");
    run_access(8'h00, 18, 0, "R11");
    run_access(8'hFF, 18, 0, "R11");
    run_access(8'h5A, 18, 0, "R11");
    run_access(8'h80, 17, 0, "R11");
    run_access(8'h7F, 18, 0, "R11");
    run_access(8'h01, 16, 0, "R11");
    run_access(8'h3C, 18, 3, "R9");

    // R10: short window is a no-op, full window returns to idle
    run_access(8'hC3, 4, 0, "R3");
    saved = trial_a;
    @(negedge clk) sclk = 1'b1;
    tick(SEL - 1);
    sclk = 1'b0;
    tick(2);
    check_eq("R10", "busy after short window", busy_a, 1);
    check_eq("R10", "trial after short window", trial_a, saved);
    sclk = 1'b1;
    tick(SEL);
    check_eq("R10", "trial after select reset", trial_a, 0);
    check_eq("R10", "busy after select reset", busy_a, 0);
    check_eq("R10", "hold variant trial after select reset", trial_b, 0);
    sclk = 1'b0;
    tick(2);
    run_access(8'h96, 18, 0, "R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule